// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one already-synchronized input pin and, when a chosen kind of edge event occurs, copies the count of one of two free-running timers into a 16-bit capture register. The event can be a single falling edge, a single rising edge, or a rising edge that completes a group of four or sixteen rising edges. Each capture raises an interrupt request flag that stays set until software clears it.

Software can read and write the capture register as a low byte and a high byte. A new capture replaces an unread value with no overrun indication. The edge detector looks only at the pin level, so toggling the pin from the port side triggers captures just as an external signal does. Writing the mode register clears the edge-group counter. An edge that lands in the same cycle as that write is judged under the new mode, which is how a spurious capture can appear when the mode changes. Software should clear the flag after changing the mode.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture value is 0, the flag is 0 and the mode register holds 4'b0000, so capture is disabled.
- R2: With mode 4'b0100, every cycle in which `pin_sync` is 0 and was 1 in the previous cycle is a capture event. The captured value appears on `cap_hi`/`cap_lo` one cycle after the edge is seen.
- R3: With mode 4'b0101, every cycle in which `pin_sync` is 1 and was 0 in the previous cycle is a capture event.
- R4: With mode 4'b0110, the 4th, 8th, 12th, ... rising edge counted since the last mode write is a capture event. The other rising edges and all falling edges are not.
- R5: With mode 4'b0111, every 16th rising edge counted since the last mode write is a capture event.
- R6: Any mode value other than 4'b0100 to 4'b0111 produces no capture: neither the capture value nor the flag changes on any edge.
- R7: A capture loads `tmr_a` when `tmr_sel` is 0 and `tmr_b` when `tmr_sel` is 1, sampled in the event cycle.
- R8: A capture sets `flag`. The flag stays set until a cycle with `flag_clr` high and no capture. If a clear and a capture fall in the same cycle, the flag stays set.
- R9: A capture while the flag is still set overwrites the stored value with the new count.
- R10: `wr_lo` and `wr_hi` load `wr_data` into the low and high byte. If a capture happens in the same cycle, the capture value wins in both bytes.
- R11: A write of the mode register (`mode_wr`) clears the edge-group count. An edge in the write cycle is judged under the newly written mode: a single-edge mode captures it, a grouped mode does not count it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_a | input | 16 | Count of the first timer |
| tmr_b | input | 16 | Count of the second timer |
| tmr_sel | input | 1 | Timer choice: 0 first, 1 second |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | New mode value |
| pin_sync | input | 1 | Synchronized capture pin level |
| wr_lo | input | 1 | Write strobe for the low capture byte |
| wr_hi | input | 1 | Write strobe for the high capture byte |
| wr_data | input | 8 | Byte written by software |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| cap_lo | output | 8 | Low byte of the capture register |
| cap_hi | output | 8 | High byte of the capture register |
| flag | output | 1 | Interrupt request flag |

## Verification
Two pairs of functions can land in one cycle: a flag clear with a capture, and a byte write with a capture. A third coincidence is a mode write with a pin edge. The bench provokes each by driving the strobe and the pin transition in the same cycle. It then judges the outcome from the requirement's stated priority: the flag stays set, the capture value replaces the written byte, and a single-edge mode captures the coincident edge. A full sweep over all sixteen mode codes with a toggling pin compares each cycle against a count-based model of which edges must capture.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  localparam logic [3:0] MODE_FALL   = 4'b0100;
  localparam logic [3:0] MODE_RISE   = 4'b0101;
  localparam logic [3:0] MODE_RISE4  = 4'b0110;
  localparam logic [3:0] MODE_RISE16 = 4'b0111;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_FALL,
    EV_RISE,
    EV_RISE_GRP
  } ev_kind_e;

  function automatic ev_kind_e decode_kind(input logic [3:0] m);
    case (m)
      MODE_FALL:               return EV_FALL;
      MODE_RISE:               return EV_RISE;
      MODE_RISE4, MODE_RISE16: return EV_RISE_GRP;
      default:                 return EV_NONE;
    endcase
  endfunction

  // Number of rising edges that make up one capture event.
  function automatic int unsigned group_len(input logic [3:0] m);
    case (m)
      MODE_RISE4:  return 4;
      MODE_RISE16: return 16;
      default:     return 1;
    endcase
  endfunction

endpackage

// File: rtl/tcap_edge.sv
module tcap_edge
  import tcap_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_sync,
  input  logic [3:0] mode_eff,
  input  logic       mode_wr,
  output logic       evt
);

  logic            pin_q;
  logic            rise;
  logic            fall;
  logic            last;
  logic [PS_W-1:0] cnt;
  ev_kind_e        kind;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_sync;
  end

  assign rise = pin_sync & ~pin_q;
  assign fall = ~pin_sync & pin_q;
  assign kind = decode_kind(mode_eff);
  assign last = (cnt == PS_W'(group_len(mode_eff) - 1));

  always_comb begin
    case (kind)
      EV_FALL:     evt = fall;
      EV_RISE:     evt = rise;
      EV_RISE_GRP: evt = rise & ~mode_wr & last;
      default:     evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      cnt <= '0;
    end else if (kind == EV_RISE_GRP && rise) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tcap_capreg.sv
module tcap_capreg #(
  parameter int TW = 16,
  localparam int NB = TW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [TW-1:0] tmr_pick,
  input  logic [NB-1:0] wr_byte,
  input  logic [7:0]    wr_data,
  output logic [TW-1:0] cap
);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)          cap[8*b +: 8] <= '0;
      else if (evt)        cap[8*b +: 8] <= tmr_pick[8*b +: 8];
      else if (wr_byte[b]) cap[8*b +: 8] <= wr_data;
    end
  end

endmodule

// File: rtl/tcap_flag.sv
module tcap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int TW   = 16,
  parameter int PS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          tmr_sel,
  input  logic          mode_wr,
  input  logic [3:0]    mode_wdata,
  input  logic          pin_sync,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wr_data,
  input  logic          flag_clr,
  output logic [7:0]    cap_lo,
  output logic [TW-9:0] cap_hi,
  output logic          flag
);

  logic [3:0]    mode_q;
  logic [3:0]    mode_eff;
  logic          cap_evt;
  logic [TW-1:0] tmr_pick;
  logic [TW-1:0] cap;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= 4'b0000;
    else if (mode_wr) mode_q <= mode_wdata;
  end

  assign mode_eff = mode_wr ? mode_wdata : mode_q;
  assign tmr_pick = tmr_sel ? tmr_b : tmr_a;

  tcap_edge #(.PS_W(PS_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .mode_eff (mode_eff),
    .mode_wr  (mode_wr),
    .evt      (cap_evt)
  );

  tcap_capreg #(.TW(TW)) u_capreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (cap_evt),
    .tmr_pick (tmr_pick),
    .wr_byte  ({wr_hi, wr_lo}),
    .wr_data  (wr_data),
    .cap      (cap)
  );

  tcap_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (cap_evt),
    .clr   (flag_clr),
    .flag  (flag)
  );

  assign cap_lo = cap[7:0];
  assign cap_hi = cap[TW-1:8];

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_evt,
  input logic [TW-1:0] tmr_pick,
  input logic [7:0]    cap_lo,
  input logic [TW-9:0] cap_hi,
  input logic          flag,
  input logic          flag_clr,
  input logic          wr_lo,
  input logic          mode_wr,
  input logic [3:0]    mode_q
);

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag);

  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !flag);

  assert_cap_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ({cap_hi, cap_lo} == $past(tmr_pick)));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr && mode_q[3:2] != 2'b01) |-> !cap_evt);

  assert_lo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !wr_lo) |=> $stable(cap_lo));

endmodule

bind tcap_unit tcap_checker #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_evt  (cap_evt),
  .tmr_pick (tmr_pick),
  .cap_lo   (cap_lo),
  .cap_hi   (cap_hi),
  .flag     (flag),
  .flag_clr (flag_clr),
  .wr_lo    (wr_lo),
  .mode_wr  (mode_wr),
  .mode_q   (mode_q)
);

// File: tb/tb_tcap_unit.sv
module tb_tcap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_a = '0;
  logic [15:0] tmr_b = '0;
  logic        tmr_sel = 1'b0;
  logic        mode_wr = 1'b0;
  logic [3:0]  mode_wdata = '0;
  logic        pin_sync = 1'b0;
  logic        wr_lo = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        flag_clr = 1'b0;
  logic [7:0]  cap_lo;
  logic [7:0]  cap_hi;
  logic        flag;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tcap_unit dut (
    .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_sel(tmr_sel),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .pin_sync(pin_sync),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .flag(flag)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: inputs already driven after a falling edge; sample 1 ns after the rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
    mode_wr = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; flag_clr = 1'b0;
  endtask

  function automatic bit should_fire(input int m, input bit rising, input int nrise);
    case (m)
      4: return !rising;
      5: return rising;
      6: return rising && (nrise % 4 == 0);
      7: return rising && (nrise % 16 == 0);
      default: return 1'b0;
    endcase
  endfunction

  logic [15:0] exp_cap;
  logic        exp_flag;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 cap", {cap_hi, cap_lo}, 16'h0000);
    chk("R1 flag", {15'd0, flag}, 16'd0);
    exp_cap = '0; exp_flag = 1'b0;

    // Sweep every mode code with 32 pin toggles.
    for (int m = 0; m < 16; m++) begin
      int nrise;
      string tag;
      nrise = 0;
      tag = (m == 4) ? "R2" : (m == 5) ? "R3" : (m == 6) ? "R4" : (m == 7) ? "R5" : "R6";
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = 4'(m); flag_clr = 1'b1; pin_sync = 1'b0;
      tick();
      exp_flag = 1'b0;
      chk("R8 clear", {15'd0, flag}, 16'd0);
      tmr_sel = m[0];
      for (int k = 0; k < 32; k++) begin
        bit rising;
        bit fire;
        bit was_set;
        @(negedge clk);
        pin_sync = ~pin_sync;
        tmr_a = 16'(m * 256 + k * 3 + 1);
        tmr_b = 16'hF000 ^ 16'(m * 97 + k * 5);
        rising = pin_sync;
        if (rising) nrise++;
        fire = should_fire(m, rising, nrise);
        was_set = exp_flag;
        if (fire) begin
          exp_cap = m[0] ? tmr_b : tmr_a;
          exp_flag = 1'b1;
        end
        tick();
        chk(was_set && fire ? {tag, " R7 R9"} : {tag, " R7"}, {cap_hi, cap_lo}, exp_cap);
        chk({tag, " R8 flag"}, {15'd0, flag}, {15'd0, exp_flag});
      end
    end

    // R11: edge in the same cycle as a mode write to single rising mode.
    @(negedge clk);
    flag_clr = 1'b1; tick();
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = 4'b0101; pin_sync = 1'b1; tmr_sel = 1'b0; tmr_a = 16'hABCD;
    tick();
    chk("R11 coincident edge cap", {cap_hi, cap_lo}, 16'hABCD);
    chk("R11 coincident edge flag", {15'd0, flag}, 16'd1);

    // R8: clear coinciding with capture keeps the flag.
    @(negedge clk); pin_sync = 1'b0; tick();
    @(negedge clk); pin_sync = 1'b1; tmr_a = 16'h1234; flag_clr = 1'b1; tick();
    chk("R8 clear vs capture flag", {15'd0, flag}, 16'd1);
    chk("R8 clear vs capture cap", {cap_hi, cap_lo}, 16'h1234);
    @(negedge clk); pin_sync = 1'b0; flag_clr = 1'b1; tick();
    chk("R8 clear alone", {15'd0, flag}, 16'd0);

    // R10: byte writes and collision with a capture.
    @(negedge clk); wr_lo = 1'b1; wr_data = 8'h5A; tick();
    chk("R10 write low", {cap_hi, cap_lo}, 16'h125A);
    @(negedge clk); wr_hi = 1'b1; wr_data = 8'hC3; tick();
    chk("R10 write high", {cap_hi, cap_lo}, 16'hC35A);
    chk("R10 write leaves flag", {15'd0, flag}, 16'd0);
    @(negedge clk); wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'h77; pin_sync = 1'b1; tmr_a = 16'h4321; tick();
    chk("R10 capture beats write", {cap_hi, cap_lo}, 16'h4321);

    // R11: rewriting the mode restarts the group of four.
    @(negedge clk); pin_sync = 1'b0; flag_clr = 1'b1; mode_wr = 1'b1; mode_wdata = 4'b0110; tick();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pin_sync = 1'b1; tmr_a = 16'(k + 16'h0900); tick();
      @(negedge clk); pin_sync = 1'b0; tick();
    end
    chk("R11 three rises no capture", {15'd0, flag}, 16'd0);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 4'b0110; tick();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pin_sync = 1'b1; tmr_a = 16'(k + 16'h0A00); tick();
      @(negedge clk); pin_sync = 1'b0; tick();
    end
    chk("R11 count restarted", {15'd0, flag}, 16'd0);
    chk("R11 value kept", {cap_hi, cap_lo}, 16'h4321);
    @(negedge clk); pin_sync = 1'b1; tmr_a = 16'hBEEF; tick();
    chk("R11 fourth rise captures", {cap_hi, cap_lo}, 16'hBEEF);
    chk("R4 fourth rise flag", {15'd0, flag}, 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule